// File: doc/BRIEF.md
# Masked RTC Alarm Comparator

This block holds an alarm setting of four time fields (seconds, minutes, hours, day of month) and compares it with the running time of a real-time clock. It makes the comparison once for each one-second tick. Each field carries a mask bit that is active low, so a field takes part in the comparison only when its mask bit is 0. The masks therefore set how often the alarm fires: a setting that checks only the seconds fires once a minute, and a setting that checks all four fields fires once a month. On a hit the block raises an alarm flag. The interrupt output is the flag qualified by an enable input, and a read of the flags register clears the flag.

Software changes the alarm through a small register port. Writes to the alarm registers are accepted only while an edit bit in the flags register is 1, and they land in a staging copy. The comparator keeps using the previous setting until software writes the edit bit back to 0. At that write the staged setting is committed in a single cycle, so the comparator never sees a half-written alarm.

Two small state machines control the block. The edit machine has the states ST_LIVE and ST_EDIT. It takes the transition *open* (ST_LIVE to ST_EDIT) on a write to the flags register with bit 0 set. It takes the transition *commit* (ST_EDIT to ST_LIVE) on a write to the flags register with bit 0 clear, and the staged alarm is copied to the active alarm at that write. The flag machine has the states FL_CLEAR and FL_RAISED. It takes the transition *hit* (FL_CLEAR to FL_RAISED) on a tick whose time matches the active alarm. It takes the transition *ack* (FL_RAISED to FL_CLEAR) on a read of the flags register in a cycle without a hit.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, the edit bit and the alarm flag are 0 and irq is 0. Every alarm register reads 0x80: mask set, value 0.
- R2: The register map is as follows. Address 0 holds the flags: bit 0 is the edit bit (read/write) and bit 1 is the alarm flag (read-only). Addresses 1, 2, 3 and 4 hold the alarm for seconds, minutes, hours and day. In each alarm register, bit 7 is the mask and bits 6:0 are the BCD value. Any other address reads 0 and ignores writes.
- R3: A write to an alarm register while the edit bit is 0 is ignored, and its readback is unchanged. While the edit bit is 1, the write is stored and reads back at once.
- R4: The comparison uses the last committed setting. Staged values take effect only on the write that clears the edit bit while it is 1.
- R5: On a cycle with tick_1hz high, a hit occurs when every field whose mask is 0 equals its current-time input. A hit sets the alarm flag at that clock edge.
- R6: If the seconds mask is 1, no hit occurs whatever the other fields hold. This includes the all-masks-set setting, which disables the alarm.
- R7: With only the seconds mask at 0, the alarm fires in each minute whose seconds match. With all masks at 0, it fires only on an exact match of day, hour, minute and second.
- R8: A read of address 0 returns the flags as they stood before the edge and clears the alarm flag at that edge. If a hit occurs in the same cycle, the flag stays 1.
- R9: irq is 1 exactly when the alarm flag is 1 and irq_en is 1, in the same cycle. It drops in the cycle after a clearing read.
- R10: Without tick_1hz, a matching time never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_date | input | 7 | Current day of month, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on address 0) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq_en | input | 1 | Alarm interrupt enable |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with its default parameters: 7-bit BCD fields, four fields and a 3-bit address. At these values every address, including the unused ones, can be reached. The four-field setting exercises the once-a-minute and exact-match modes directly. The bench also places a read of the flags register in the same cycle as a matching tick, which reaches the set-wins case. It retunes the alarm while the edit bit is 1 and then fires the old setting, which shows that the comparator still uses the committed values until the commit write.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    // edit machine: comparator runs on committed values / staging is open
    typedef enum logic {
        ST_LIVE,
        ST_EDIT
    } edit_state_t;

    // alarm flag machine
    typedef enum logic {
        FL_CLEAR,
        FL_RAISED
    } flag_state_t;

    // field index order used by the register map (address = index + 1)
    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DATE = 3;

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int VAL_W  = 7,
    parameter int NFIELD = 4,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [VAL_W:0]                 wdata,
    input  logic                           flag_in,
    output logic [VAL_W:0]                 rdata,
    output logic                           edit,
    output logic [NFIELD-1:0][VAL_W-1:0]   act_val,
    output logic [NFIELD-1:0]              act_mask
);

    localparam logic [ADDR_W-1:0] FLAGS_ADDR = '0;

    edit_state_t                  state_q, state_d;
    logic                         wr_flags;
    logic                         commit;
    logic [NFIELD-1:0][VAL_W-1:0] stage_val;
    logic [NFIELD-1:0]            stage_mask;

    assign wr_flags = wr && (addr == FLAGS_ADDR);

    // transitions: open (LIVE->EDIT), commit (EDIT->LIVE)
    always_comb begin
        state_d = state_q;
        commit  = 1'b0;
        unique case (state_q)
            ST_LIVE: if (wr_flags && wdata[0])  state_d = ST_EDIT;
            ST_EDIT: if (wr_flags && !wdata[0]) begin
                state_d = ST_LIVE;
                commit  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LIVE;
        else        state_q <= state_d;
    end

    // staged and active copies, one slice per field
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_val[g]  <= '0;
                stage_mask[g] <= 1'b1;
                act_val[g]    <= '0;
                act_mask[g]   <= 1'b1;
            end else begin
                if (state_q == ST_EDIT && wr && addr == ADDR_W'(g + 1)) begin
                    stage_val[g]  <= wdata[VAL_W-1:0];
                    stage_mask[g] <= wdata[VAL_W];
                end
                if (commit) begin
                    act_val[g]  <= stage_val[g];
                    act_mask[g] <= stage_mask[g];
                end
            end
        end
    end

    assign edit = (state_q == ST_EDIT);

    always_comb begin
        rdata = '0;
        if (addr == FLAGS_ADDR) begin
            rdata[0] = edit;
            rdata[1] = flag_in;
        end
        for (int i = 0; i < NFIELD; i++) begin
            if (addr == ADDR_W'(i + 1)) rdata = {stage_mask[i], stage_val[i]};
        end
    end

    // R3: staging cannot move while the edit bit is clear
    p_locked_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LIVE) |=> ($stable(stage_val) && $stable(stage_mask)));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
#(
    parameter int VAL_W  = 7,
    parameter int NFIELD = 4
) (
    input  logic                          tick,
    input  logic [NFIELD-1:0][VAL_W-1:0]  cur_val,
    input  logic [NFIELD-1:0][VAL_W-1:0]  act_val,
    input  logic [NFIELD-1:0]             act_mask,
    output logic                          hit
);

    logic [NFIELD-1:0] fld_ok;

    // a masked field always agrees; an unmasked one must be equal
    for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
        assign fld_ok[g] = act_mask[g] || (cur_val[g] == act_val[g]);
    end

    // the seconds field must take part, otherwise the alarm is off
    assign hit = tick && !act_mask[FLD_SEC] && (&fld_ok);

endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
    import rtc_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    flag_state_t state_q, state_d;

    // transitions: hit (CLEAR->RAISED), ack (RAISED->CLEAR, lost to a hit)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR:  if (hit)         state_d = FL_RAISED;
            FL_RAISED: if (ack && !hit) state_d = FL_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FL_RAISED);
        irq  = flag && irq_en;
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
#(
    parameter int VAL_W  = 7,
    parameter int NFIELD = 4,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic [VAL_W-1:0]  cur_sec,
    input  logic [VAL_W-1:0]  cur_min,
    input  logic [VAL_W-1:0]  cur_hour,
    input  logic [VAL_W-1:0]  cur_date,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [VAL_W:0]    reg_wdata,
    output logic [VAL_W:0]    reg_rdata,
    input  logic              irq_en,
    output logic              irq
);

    logic [NFIELD-1:0][VAL_W-1:0] cur_val;
    logic [NFIELD-1:0][VAL_W-1:0] act_val;
    logic [NFIELD-1:0]            act_mask;
    logic                         edit;
    logic                         hit;
    logic                         ack;
    logic                         flag;

    always_comb begin
        cur_val           = '0;
        cur_val[FLD_SEC]  = cur_sec;
        cur_val[FLD_MIN]  = cur_min;
        cur_val[FLD_HOUR] = cur_hour;
        cur_val[FLD_DATE] = cur_date;
    end

    assign ack = reg_rd && (reg_addr == '0);

    rtc_alarm_regs #(.VAL_W(VAL_W), .NFIELD(NFIELD), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .flag_in  (flag),
        .rdata    (reg_rdata),
        .edit     (edit),
        .act_val  (act_val),
        .act_mask (act_mask)
    );

    rtc_alarm_match #(.VAL_W(VAL_W), .NFIELD(NFIELD)) u_match (
        .tick     (tick_1hz),
        .cur_val  (cur_val),
        .act_val  (act_val),
        .act_mask (act_mask),
        .hit      (hit)
    );

    rtc_alarm_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .ack    (ack),
        .irq_en (irq_en),
        .flag   (flag),
        .irq    (irq)
    );

    // R5: a hit raises the flag at the next edge
    p_hit_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R8: a flags read without a hit leaves the flag clear
    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !flag);

    // R10: no tick, no new flag
    p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_1hz && !flag) |=> !flag);

    // R6: seconds excluded means the alarm is off
    p_sec_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mask[FLD_SEC] && !flag) |=> !flag);

    // R4: the active setting holds during an edit until the commit write
    p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edit && !(reg_wr && reg_addr == '0 && !reg_wdata[0]))
            |=> ($stable(act_val) && $stable(act_mask)));

endmodule

// File: tb/rtc_alarm_cmp_bench.sv
module rtc_alarm_cmp_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_en = 1'b0;
    logic       irq;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    rtc_alarm_cmp u_rtc_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_en(irq_en), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int m_w, m_af;
    int m_sv[4], m_sm[4], m_av[4], m_am[4];

    function automatic int cur_of(int f);
        case (f)
            0: return int'(cur_sec);
            1: return int'(cur_min);
            2: return int'(cur_hour);
            default: return int'(cur_date);
        endcase
    endfunction

    function automatic int exp_rd(int a);
        if (a == 0) return m_af * 2 + m_w;
        if (a >= 1 && a <= 4) return m_sm[a-1] * 128 + m_sv[a-1];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_w = 0; m_af = 0;
            for (int f = 0; f < 4; f++) begin
                m_sv[f] = 0; m_sm[f] = 1; m_av[f] = 0; m_am[f] = 1;
            end
        end else begin
            int hitv;
            hitv = (tick_1hz && m_am[0] == 0) ? 1 : 0;
            for (int f = 0; f < 4; f++)
                if (m_am[f] == 0 && cur_of(f) != m_av[f]) hitv = 0;
            if (reg_rd && reg_addr == 0) m_af = 0;
            if (hitv != 0) m_af = 1;
            if (reg_wr) begin
                if (reg_addr == 0) begin
                    if (m_w == 1 && !reg_wdata[0])
                        for (int f = 0; f < 4; f++) begin
                            m_av[f] = m_sv[f]; m_am[f] = m_sm[f];
                        end
                    m_w = int'(reg_wdata[0]);
                end else if (reg_addr >= 1 && reg_addr <= 4 && m_w == 1) begin
                    m_sv[reg_addr-1] = int'(reg_wdata[6:0]);
                    m_sm[reg_addr-1] = int'(reg_wdata[7]);
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq == (m_af == 1 && irq_en), {cur_req, " irq vs model (R9)"},
                int'(irq), (m_af == 1 && irq_en) ? 1 : 0);
            if (reg_rd)
                chk(int'(reg_rdata) == exp_rd(int'(reg_addr)), {cur_req, " rdata vs model"},
                    int'(reg_rdata), exp_rd(int'(reg_addr)));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(int a, int d);
        @(posedge clk); #2;
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(int a, int exp, string req);
        @(posedge clk); #2;
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        chk(int'(reg_rdata) == exp, req, int'(reg_rdata), exp);
        @(posedge clk); #2;
        reg_rd = 1'b0;
    endtask

    task automatic do_tick(int d, int h, int m, int s);
        @(posedge clk); #2;
        cur_date = 7'(d); cur_hour = 7'(h); cur_min = 7'(m); cur_sec = 7'(s);
        tick_1hz = 1'b1;
        @(posedge clk); #2;
        tick_1hz = 1'b0;
    endtask

    task automatic expect_irq(int exp, string req);
        @(negedge clk);
        chk(int'(irq) == exp, req, int'(irq), exp);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;

        cur_req = "R1";
        rd_expect(0, 8'h00, "R1");
        for (int a = 1; a <= 4; a++) rd_expect(a, 8'h80, "R1");
        expect_irq(0, "R1");

        cur_req = "R3";
        wr(1, 8'h15);
        rd_expect(1, 8'h80, "R3");

        cur_req = "R2";
        wr(5, 8'h55);
        rd_expect(5, 8'h00, "R2");
        wr(0, 8'h01);
        rd_expect(0, 8'h01, "R2");

        cur_req = "R3";
        wr(1, 8'h30); wr(2, 8'h80); wr(3, 8'h80); wr(4, 8'h80);
        rd_expect(1, 8'h30, "R3");

        cur_req = "R4";
        irq_en = 1'b1;
        do_tick(8'h01, 8'h00, 8'h12, 8'h30);
        expect_irq(0, "R4");
        rd_expect(0, 8'h01, "R4");
        wr(0, 8'h00);

        cur_req = "R5";
        do_tick(8'h01, 8'h00, 8'h12, 8'h29);
        expect_irq(0, "R5");
        cur_req = "R7";
        do_tick(8'h01, 8'h00, 8'h12, 8'h30);
        expect_irq(1, "R7");

        cur_req = "R9";
        irq_en = 1'b0;
        expect_irq(0, "R9");
        irq_en = 1'b1;
        expect_irq(1, "R9");

        cur_req = "R8";
        rd_expect(0, 8'h02, "R8");
        rd_expect(0, 8'h00, "R8");
        expect_irq(0, "R9");

        cur_req = "R10";
        repeat (5) @(posedge clk);
        rd_expect(0, 8'h00, "R10");

        cur_req = "R7";
        do_tick(8'h01, 8'h00, 8'h13, 8'h30);
        expect_irq(1, "R7");
        rd_expect(0, 8'h02, "R7");

        cur_req = "R6";
        wr(0, 8'h01); wr(1, 8'h80); wr(2, 8'h13); wr(0, 8'h00);
        do_tick(8'h01, 8'h00, 8'h13, 8'h30);
        expect_irq(0, "R6");
        rd_expect(0, 8'h00, "R6");

        cur_req = "R7";
        wr(0, 8'h01); wr(1, 8'h00); wr(2, 8'h45); wr(3, 8'h08); wr(4, 8'h15); wr(0, 8'h00);
        do_tick(8'h16, 8'h08, 8'h45, 8'h00);
        expect_irq(0, "R5");
        do_tick(8'h15, 8'h08, 8'h45, 8'h00);
        expect_irq(1, "R7");

        // R8: read and hit in the same cycle, set wins
        cur_req = "R8";
        @(posedge clk); #2;
        reg_rd = 1'b1; reg_addr = 3'd0; tick_1hz = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 8'h02, "R8 same-cycle read", int'(reg_rdata), 8'h02);
        @(posedge clk); #2;
        reg_rd = 1'b0; tick_1hz = 1'b0;
        rd_expect(0, 8'h02, "R8");
        rd_expect(0, 8'h00, "R8");

        // R4: retune during edit; old setting still fires until commit
        cur_req = "R4";
        wr(0, 8'h01); wr(4, 8'h20);
        do_tick(8'h15, 8'h08, 8'h45, 8'h00);
        expect_irq(1, "R4");
        rd_expect(0, 8'h03, "R4");
        wr(0, 8'h00);
        do_tick(8'h15, 8'h08, 8'h45, 8'h00);
        expect_irq(0, "R4");
        do_tick(8'h20, 8'h08, 8'h45, 8'h00);
        expect_irq(1, "R4");
        rd_expect(0, 8'h02, "R4");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule